// File: doc/BRIEF.md
# Diagnostic Test-Pin Selector with Bypass Dividers

This block drives the single diagnostic pin of a clock synthesizer. A 3-bit test code picks one of eight sources for the pin: the serial configuration bit stream, a fixed high or low level, the reference clock divided by sixteen, the feedback-counter pulse, the synthesized clock, or the synthesized clock divided by four. The phase-locked loop is outside the block. Its output is an input here, named the synthesized clock.

One code selects bypass mode. The slow serial clock then takes the place of the loop. It feeds the post-divider, whose output becomes the main clock output. It also feeds the feedback counter, whose pulse goes to the diagnostic pin. This gives board-level debug a clock tree that moves at a controlled, low rate.

Every incoming clock and the serial bit are oversampled by one fast system clock through two-stage synchronizers. Edges are found from the synchronized levels. All counting and both outputs live in that single domain, and both outputs are registered.

Top module: `tsel_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `test_o` and `fout_o` are 0.
- R2: Test code 3'b001 holds `test_o` at 1. Test code 3'b101 holds `test_o` at 0.
- R3: Test code 3'b000 makes `test_o` follow `ser_bit_i`, three `clk` rising edges after `ser_bit_i` changes.
- R4: Test code 3'b010 drives `test_o` with a square wave whose period is 16 periods of `ref_clk_i`.
- R5: Test code 3'b100 drives `test_o` with a copy of `synth_clk_i`. Test code 3'b111 drives it with a square wave whose period is 4 periods of `synth_clk_i`.
- R6: Test code 3'b011 drives `test_o` with the feedback-counter pulse. The pulse is one `clk` cycle wide and comes once per `m_val_i` rising edges of `synth_clk_i`. An `m_val_i` of 0 acts as 1.
- R7: Test code 3'b110 selects bypass mode. In this mode `fout_o` toggles once per N rising edges of `ser_clk_i`, where `n_code_i` values 0, 1, 2 and 3 give N = 1, 2, 4 and 8. `test_o` then carries the counter pulse, once per `m_val_i` rising edges of `fout_o`.
- R8: Entering or leaving bypass mode clears the post-divider and the counter. On entry, `fout_o` is therefore 0 until the first toggle.
- R9: A new test code takes effect on `test_o` at the third `clk` rising edge after it is applied.
- R10: Outside bypass mode, `fout_o` follows `synth_clk_i`, three `clk` rising edges late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples every other clock |
| rst | input | 1 | Synchronous reset, active high |
| test_code_i | input | 3 | Selects the diagnostic source, or bypass mode |
| m_val_i | input | 9 | Feedback-counter modulus |
| n_code_i | input | 2 | Post-divider code (N = 2^code) |
| ref_clk_i | input | 1 | Reference clock |
| synth_clk_i | input | 1 | Synthesized clock from the loop |
| ser_bit_i | input | 1 | Serial-out bit of the configuration shift register |
| ser_clk_i | input | 1 | Serial configuration clock, which drives the dividers in bypass |
| test_o | output | 1 | Diagnostic pin |
| fout_o | output | 1 | Main clock output |

## Verification
The bench measures the period of each divided clock between consecutive rising edges. A divider off by one stage would show up there as a halved or doubled period. It checks all four post-divider codes in bypass, so a wrong code-to-ratio mapping, or a missing fixed divide-by-two, changes the measured period. It leaves bypass with the post-divider output high and then enters bypass again with the serial clock stopped. A design that failed to clear the dividers would bring `fout_o` back high. The three-edge latency of a code change is checked edge by edge, so a missing or extra synchronizer stage shows up as an early or late switch.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int NCODE_W = 2;
    localparam int NCNT_W  = (1 << NCODE_W) - 1;

    typedef enum logic [2:0] {
        SEL_SHIFT   = 3'b000,
        SEL_ONE     = 3'b001,
        SEL_REFDIV  = 3'b010,
        SEL_MCNT    = 3'b011,
        SEL_SYNTH   = 3'b100,
        SEL_ZERO    = 3'b101,
        SEL_BYPASS  = 3'b110,
        SEL_SYNDIV4 = 3'b111
    } tsel_code_e;

    typedef struct packed {
        logic ser_bit;
        logic ser_clk;
        logic synth;
        logic refc;
    } tsel_lanes_t;

    // last count value of the post-divider for a given code (ratio 2^code)
    function automatic logic [NCNT_W-1:0] n_last(input logic [NCODE_W-1:0] code);
        logic [NCNT_W:0] ratio;
        ratio = ({{NCNT_W{1'b0}}, 1'b1} << code);
        return ratio[NCNT_W-1:0] - {{(NCNT_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/tsel_sync.sv
module tsel_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_lane
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= async_i[g];
                s2 <= s1;
            end
        end
        assign sync_o[g] = s2;
    end
endmodule

// File: rtl/tsel_pow2_div.sv
module tsel_pow2_div #(
    parameter int LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output logic q_o
);
    localparam int CW = LOG2 - 1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            q_o <= 1'b0;
        end else if (step_i) begin
            cnt <= cnt + 1'b1;
            if (&cnt) q_o <= ~q_o;
        end
    end

    // toggle only on a step
    a_r4_toggle_on_step: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(q_o));
endmodule

// File: rtl/tsel_ndiv.sv
module tsel_ndiv
    import tsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               step_i,
    input  logic [NCODE_W-1:0] n_code_i,
    output logic               q_o,
    output logic               rise_o
);
    logic [NCNT_W-1:0] cnt;
    logic              wrap;

    assign wrap   = step_i && (cnt >= n_last(n_code_i));
    assign rise_o = wrap && !q_o && !clr_i;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt <= '0;
            q_o <= 1'b0;
        end else if (step_i) begin
            if (wrap) begin
                cnt <= '0;
                q_o <= ~q_o;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r8_clear_low: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !q_o);
endmodule

// File: rtl/tsel_mcount.sv
module tsel_mcount #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_i,
    input  logic           step_i,
    input  logic [M_W-1:0] m_i,
    output logic           pulse_o
);
    logic [M_W-1:0] cnt;
    logic [M_W-1:0] reload;

    assign reload = (m_i == '0) ? '0 : m_i - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt     <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= 1'b0;
            if (step_i) begin
                if (cnt == '0) begin
                    cnt     <= reload;
                    pulse_o <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    a_r6_pulse_single: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/tsel_top.sv
module tsel_top
    import tsel_pkg::*;
#(
    parameter int M_W = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         test_code_i,
    input  logic [M_W-1:0]     m_val_i,
    input  logic [NCODE_W-1:0] n_code_i,
    input  logic               ref_clk_i,
    input  logic               synth_clk_i,
    input  logic               ser_bit_i,
    input  logic               ser_clk_i,
    output logic               test_o,
    output logic               fout_o
);
    tsel_lanes_t lanes_raw, lanes_s, lanes_prev;
    logic [2:0]  code_s1;
    tsel_code_e  code_q;
    logic        byp_now, byp_d, mode_chg;
    logic        ref_rise, syn_rise, sclk_rise;
    logic        refdiv_q, syndiv_q, ndiv_q, ndiv_rise, mpulse, mstep;

    assign lanes_raw = '{ser_bit: ser_bit_i, ser_clk: ser_clk_i,
                         synth: synth_clk_i, refc: ref_clk_i};

    tsel_sync #(.W(4)) u_sync (
        .clk(clk), .rst(rst), .async_i(lanes_raw), .sync_o(lanes_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_prev <= '0;
            code_s1    <= '0;
            code_q     <= SEL_SHIFT;
            byp_d      <= 1'b0;
        end else begin
            lanes_prev <= lanes_s;
            code_s1    <= test_code_i;
            code_q     <= tsel_code_e'(code_s1);
            byp_d      <= byp_now;
        end
    end

    assign ref_rise  = lanes_s.refc    && !lanes_prev.refc;
    assign syn_rise  = lanes_s.synth   && !lanes_prev.synth;
    assign sclk_rise = lanes_s.ser_clk && !lanes_prev.ser_clk;
    assign byp_now   = (code_q == SEL_BYPASS);
    assign mode_chg  = byp_now ^ byp_d;

    tsel_pow2_div #(.LOG2(4)) u_refdiv (
        .clk(clk), .rst(rst), .step_i(ref_rise), .q_o(refdiv_q)
    );

    tsel_pow2_div #(.LOG2(2)) u_syndiv (
        .clk(clk), .rst(rst), .step_i(syn_rise), .q_o(syndiv_q)
    );

    tsel_ndiv u_ndiv (
        .clk(clk), .rst(rst), .clr_i(mode_chg), .step_i(byp_d && sclk_rise),
        .n_code_i(n_code_i), .q_o(ndiv_q), .rise_o(ndiv_rise)
    );

    assign mstep = byp_d ? ndiv_rise : syn_rise;

    tsel_mcount #(.M_W(M_W)) u_mcnt (
        .clk(clk), .rst(rst), .clr_i(mode_chg), .step_i(mstep),
        .m_i(m_val_i), .pulse_o(mpulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            test_o <= 1'b0;
            fout_o <= 1'b0;
        end else begin
            fout_o <= byp_d ? ndiv_q : lanes_s.synth;
            unique case (code_q)
                SEL_SHIFT:   test_o <= lanes_s.ser_bit;
                SEL_ONE:     test_o <= 1'b1;
                SEL_REFDIV:  test_o <= refdiv_q;
                SEL_MCNT:    test_o <= mpulse;
                SEL_SYNTH:   test_o <= lanes_s.synth;
                SEL_ZERO:    test_o <= 1'b0;
                SEL_BYPASS:  test_o <= mpulse;
                SEL_SYNDIV4: test_o <= syndiv_q;
                default:     test_o <= 1'b0;
            endcase
        end
    end

    a_r2_const_one: assert property (@(posedge clk) disable iff (rst)
        (code_q == SEL_ONE) |=> test_o);
    a_r2_const_zero: assert property (@(posedge clk) disable iff (rst)
        (code_q == SEL_ZERO) |=> !test_o);
    a_r7_bypass_src: assert property (@(posedge clk) disable iff (rst)
        (byp_d && byp_now) |=> (fout_o == $past(ndiv_q)));
    a_r10_normal_src: assert property (@(posedge clk) disable iff (rst)
        (!byp_d && !byp_now) |=> (fout_o == $past(lanes_s.synth)));
endmodule

// File: tb/sim_tsel_top.sv
module sim_tsel_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] test_code;
    logic [8:0] m_val;
    logic [1:0] n_code;
    logic       ref_clk = 1'b0, synth_clk = 1'b0, ser_bit, ser_clk = 1'b0;
    logic       test_o, fout_o;
    logic       ref_en = 1'b0, syn_en = 1'b0, sclk_en = 1'b0;
    int         n_run = 0, n_fail = 0;
    int         cyc = 0;

    tsel_top u0 (
        .clk(clk), .rst(rst), .test_code_i(test_code), .m_val_i(m_val),
        .n_code_i(n_code), .ref_clk_i(ref_clk), .synth_clk_i(synth_clk),
        .ser_bit_i(ser_bit), .ser_clk_i(ser_clk), .test_o(test_o), .fout_o(fout_o)
    );

    always #10 clk = ~clk;

    // stimulus clocks: ref period 4, synth period 6, serial clock period 4 (in clk cycles)
    initial forever begin repeat (2) @(negedge clk); if (ref_en)  ref_clk   = ~ref_clk;   end
    initial forever begin repeat (3) @(negedge clk); if (syn_en)  synth_clk = ~synth_clk; end
    initial forever begin repeat (2) @(negedge clk); if (sclk_en) ser_clk   = ~ser_clk;   end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            summary();
        end
    end

    task automatic set_code(input logic [2:0] c);
        @(negedge clk); test_code = c;
        repeat (8) @(negedge clk);
    endtask

    // cycles between consecutive rising edges of the chosen output
    task automatic period(input bit use_fout, output int per);
        int t0;
        bit prev;
        int lim;
        per = -1; t0 = 0; lim = 0;
        prev = use_fout ? fout_o : test_o;
        for (int k = 0; k < 2; k++) begin
            forever begin
                @(negedge clk); lim++;
                if (lim > 3000) return;
                if ((use_fout ? fout_o : test_o) && !prev) begin
                    prev = 1'b1;
                    break;
                end
                prev = use_fout ? fout_o : test_o;
            end
            if (k == 0) t0 = cyc; else per = cyc - t0;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; test_code = 3'b000; m_val = 9'd5; n_code = 2'd0; ser_bit = 1'b1;
        repeat (3) @(negedge clk);
        check(test_o == 1'b0 && fout_o == 1'b0, "R1 during reset", test_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(test_o == 1'b0 && fout_o == 1'b0, "R1 after reset", fout_o, 0);
    endtask

    task automatic t_consts;
        set_code(3'b001);
        check(test_o == 1'b1, "R2 code 001", test_o, 1);
        set_code(3'b101);
        check(test_o == 1'b0, "R2 code 101", test_o, 0);
    endtask

    task automatic t_latency;
        // R9: switch 101 -> 001, new value appears at the third edge
        @(negedge clk); test_code = 3'b001;
        @(negedge clk); check(test_o == 1'b0, "R9 edge1", test_o, 0);
        @(negedge clk); check(test_o == 1'b0, "R9 edge2", test_o, 0);
        @(negedge clk); check(test_o == 1'b1, "R9 edge3", test_o, 1);
    endtask

    task automatic t_shift;
        set_code(3'b000);
        check(test_o == 1'b1, "R3 serial high", test_o, 1);
        @(negedge clk); ser_bit = 1'b0;
        repeat (2) @(negedge clk);
        check(test_o == 1'b1, "R3 not yet", test_o, 1);
        @(negedge clk);
        check(test_o == 1'b0, "R3 serial low", test_o, 0);
    endtask

    task automatic t_divs;
        int p;
        ref_en = 1'b1; syn_en = 1'b1;
        set_code(3'b010); period(1'b0, p);
        check(p == 64, "R4 ref/16 period", p, 64);
        set_code(3'b100); period(1'b0, p);
        check(p == 6, "R5 synth period", p, 6);
        set_code(3'b111); period(1'b0, p);
        check(p == 24, "R5 synth/4 period", p, 24);
        period(1'b1, p);
        check(p == 6, "R10 fout normal", p, 6);
    endtask

    task automatic t_mcnt;
        int p, w;
        m_val = 9'd5;
        set_code(3'b011); period(1'b0, p);
        check(p == 30, "R6 M=5 period", p, 30);
        w = 0;
        @(negedge clk); w = test_o;
        check(w == 0, "R6 one-cycle pulse", w, 0);
        m_val = 9'd0; period(1'b0, p); period(1'b0, p);
        check(p == 6, "R6 M=0 acts as 1", p, 6);
        syn_en = 1'b0; ref_en = 1'b0;
    endtask

    task automatic t_bypass;
        int p;
        int exp_p [4] = '{8, 16, 32, 64};
        sclk_en = 1'b1; m_val = 9'd3;
        for (int c = 0; c < 4; c++) begin
            n_code = c[1:0];
            set_code(3'b001);
            set_code(3'b110);
            period(1'b1, p);
            check(p == exp_p[c], "R7 bypass fout period", p, exp_p[c]);
        end
        n_code = 2'd1;
        set_code(3'b001); set_code(3'b110);
        period(1'b0, p);
        check(p == 48, "R7 bypass M pulse period", p, 48);
    endtask

    task automatic t_clear;
        int lim;
        lim = 0;
        while (!fout_o && lim < 500) begin @(negedge clk); lim++; end
        sclk_en = 1'b0;
        repeat (4) @(negedge clk);
        check(fout_o == 1'b1, "R8 setup high", fout_o, 1);
        set_code(3'b001);
        set_code(3'b110);
        check(fout_o == 1'b0, "R8 cleared on entry", fout_o, 0);
    endtask

    initial begin
        t_reset();
        t_consts();
        t_latency();
        t_shift();
        t_divs();
        t_mcnt();
        t_bypass();
        t_clear();
        summary();
    end
endmodule